// File: doc/BRIEF.md
# USART Bit-Rate Clock Generator

This block produces the timing strobes that a serial transmitter and receiver need. It has one reloadable down-counter that divides the system clock by a programmable value, plus a small phase counter. Together they run one of four clock modes. In normal asynchronous mode a bit lasts 16 prescaler pulses. In double-speed asynchronous mode a bit lasts 8. In master synchronous mode the block drives a serial clock pin itself. In slave synchronous mode it follows a clock that arrives on that same pin from outside.

The shift registers connect to two single-cycle strobes. `tx_tick` tells the transmitter to advance one bit. `rx_tick` tells the receiver when to sample. Any change to the divisor or to the mode restarts the timing at once. This keeps a stale, half-counted bit from leaking out.

Top module: `usart_clkgen`

## Requirements
- R1: The prescaler emits one pulse every `divisor`+1 system clocks, for any divisor from 0 to 4095. In master mode this is visible as one serial clock toggle per pulse.
- R2: With `sync_mode`=0 and `double_speed`=0, `tx_tick` is high for one cycle on every 16th prescaler pulse. The 16th pulse after a restart is the first such tick.
- R3: With `sync_mode`=0 and `double_speed`=1, `tx_tick` is high for one cycle on every 8th prescaler pulse after a restart.
- R4: In both asynchronous modes, `rx_tick` marks mid-bit. It fires on pulse 8 of each 16, or on pulse 4 of each 8.
- R5: With `sync_mode`=1 and `clk_dir_out`=1 (master), `xck_oe` is 1. `xck_out` starts at 0 after a restart and toggles after every prescaler pulse. `rx_tick` fires on the odd pulses, where the pin rises. `tx_tick` fires on the even pulses, where the pin falls.
- R6: When `sync_mode`=1, `double_speed` has no effect on any output and causes no restart.
- R7: With `sync_mode`=1 and `clk_dir_out`=0 (slave), `xck_oe` and `xck_out` are 0. A rising level on `xck_in` gives one `rx_tick` and a falling level gives one `tx_tick`. Each tick is visible after the second rising clock edge that samples the new level. The external clock must have a period of at least 4 system clocks.
- R8: When `sync_mode`=0, the pin is not driven (`xck_oe`=0, `xck_out`=0) and `xck_in` has no effect on any output.
- R9: A change in the divisor, in `sync_mode`, in the effective double-speed setting or in the effective pin direction restarts the block. No tick appears in the cycle of the change, and all counting starts over from the new settings.
- R10: While reset is held, `tx_tick`, `rx_tick` and `xck_out` are 0.
- R11: `tx_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| divisor | input | DIV_W (12) | Prescaler reload value; period is value+1 clocks |
| sync_mode | input | 1 | 0 selects asynchronous, 1 selects synchronous operation |
| double_speed | input | 1 | 1 halves the asynchronous bit length; ignored when synchronous |
| clk_dir_out | input | 1 | Synchronous only: 1 drives the pin (master), 0 follows it (slave) |
| xck_in | input | 1 | Serial clock pin level from outside |
| tx_tick | output | 1 | One-cycle strobe: transmitter advances a bit |
| rx_tick | output | 1 | One-cycle strobe: receiver samples a bit |
| xck_out | output | 1 | Serial clock value driven in master mode |
| xck_oe | output | 1 | Serial clock pin output enable |

## Verification
Some rules are checked by assertions on every cycle. These are: no tick in the cycle a divisor change lands, no back-to-back transmit ticks, an idle pin in asynchronous and slave modes, master pin toggles only right after a prescaler pulse, and tick exclusivity in asynchronous mode. The exact positions of ticks can only be shown by the bench scenarios. These are the 16- and 8-pulse bit lengths, the mid-bit sample point, the divide-by-divisor+1 period up to the largest divisor, and the two-flop latency in slave mode. The bench also shows that `xck_in` and `double_speed` are ignored in the modes where they do not apply.

// File: rtl/usart_clkgen.sv
module usart_clkgen #(
  parameter int DIV_W    = 12,
  parameter int OVS_NORM = 16,
  parameter int OVS_FAST = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  input  logic             sync_mode,
  input  logic             double_speed,
  input  logic             clk_dir_out,
  input  logic             xck_in,
  output logic             tx_tick,
  output logic             rx_tick,
  output logic             xck_out,
  output logic             xck_oe
);

  localparam int PH_W = $clog2(OVS_NORM);
  localparam logic [PH_W-1:0] LAST_NORM = PH_W'(OVS_NORM - 1);
  localparam logic [PH_W-1:0] LAST_FAST = PH_W'(OVS_FAST - 1);
  localparam logic [PH_W-1:0] MID_NORM  = PH_W'(OVS_NORM / 2 - 1);
  localparam logic [PH_W-1:0] MID_FAST  = PH_W'(OVS_FAST / 2 - 1);

  logic             armed;
  logic [DIV_W-1:0] div_q;
  logic             sync_q, fast_q, master_q;
  logic [DIV_W-1:0] cnt;
  logic [PH_W-1:0]  ph;
  logic             xck_q;
  logic [2:0]       xs;

  wire fast_eff   = double_speed & ~sync_mode;
  wire master_eff = sync_mode & clk_dir_out;
  wire slave      = sync_mode & ~clk_dir_out;

  wire restart = !armed || (divisor != div_q) || (sync_mode != sync_q)
                 || (fast_eff != fast_q) || (master_eff != master_q);

  wire pulse = !restart && !slave && (cnt == '0);

  wire [PH_W-1:0] ph_last = fast_eff ? LAST_FAST : LAST_NORM;
  wire [PH_W-1:0] ph_mid  = fast_eff ? MID_FAST  : MID_NORM;

  wire x_rise = xs[1] & ~xs[2];
  wire x_fall = ~xs[1] & xs[2];

  always_comb begin
    if (slave) begin
      tx_tick = !restart && x_fall;
      rx_tick = !restart && x_rise;
    end else if (master_eff) begin
      tx_tick = pulse && ph[0];
      rx_tick = pulse && !ph[0];
    end else begin
      tx_tick = pulse && (ph == ph_last);
      rx_tick = pulse && (ph == ph_mid);
    end
  end

  assign xck_oe  = master_eff;
  assign xck_out = master_eff & xck_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      div_q    <= '0;
      sync_q   <= 1'b0;
      fast_q   <= 1'b0;
      master_q <= 1'b0;
      cnt      <= '0;
      ph       <= '0;
      xck_q    <= 1'b0;
    end else if (restart) begin
      armed    <= 1'b1;
      div_q    <= divisor;
      sync_q   <= sync_mode;
      fast_q   <= fast_eff;
      master_q <= master_eff;
      cnt      <= divisor;
      ph       <= '0;
      xck_q    <= 1'b0;
    end else if (!slave) begin
      cnt <= (cnt == '0) ? divisor : cnt - 1'b1;
      if (pulse) begin
        if (master_eff) begin
          ph    <= ph ^ PH_W'(1);
          xck_q <= ~xck_q;
        end else begin
          ph <= (ph == ph_last) ? '0 : ph + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) xs <= '0;
    else        xs <= {xs[1:0], xck_in};
  end

  // R9
  a_r9_no_tick_on_div_change: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(divisor) |-> !tx_tick && !rx_tick);

  // R11
  a_r11_tx_not_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    tx_tick |=> !tx_tick);

  // R8
  a_r8_async_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !xck_oe && !xck_out);

  // R7
  a_r7_slave_pin_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !clk_dir_out) |-> !xck_oe && !xck_out);

  // R4
  a_r4_async_ticks_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !(tx_tick && rx_tick));

  // R5
  a_r5_master_toggle_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (master_eff && $past(master_eff) && $past(!restart) && (xck_out != $past(xck_out)))
      |-> $past(tx_tick || rx_tick));

endmodule

// File: tb/usart_clkgen_test.sv
module usart_clkgen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] divisor = '0;
  logic        sync_mode = 1'b0, double_speed = 1'b0, clk_dir_out = 1'b0, xck_in = 1'b0;
  logic        tx_tick, rx_tick, xck_out, xck_oe;
  int          vectors = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  usart_clkgen uut (
    .clk(clk), .rst_n(rst_n), .divisor(divisor), .sync_mode(sync_mode),
    .double_speed(double_speed), .clk_dir_out(clk_dir_out), .xck_in(xck_in),
    .tx_tick(tx_tick), .rx_tick(rx_tick), .xck_out(xck_out), .xck_oe(xck_oe));

  task automatic chk(input logic act, input logic exp, input string what, input int n);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at step %0d: actual %b expected %b", what, n, act, exp);
    end
  endtask

  function automatic bit on_pulse(int n, int d);
    return (n > 0) && (n % (d + 1) == 0);
  endfunction

  function automatic bit exp_async_tx(int n, int d, int ovs);
    return on_pulse(n, d) && ((n / (d + 1)) % ovs == 0);
  endfunction

  function automatic bit exp_async_rx(int n, int d, int ovs);
    return on_pulse(n, d) && ((n / (d + 1)) % ovs == ovs / 2);
  endfunction

  function automatic bit exp_master_tx(int n, int d);
    return on_pulse(n, d) && ((n / (d + 1)) % 2 == 0);
  endfunction

  function automatic bit exp_master_rx(int n, int d);
    return on_pulse(n, d) && ((n / (d + 1)) % 2 == 1);
  endfunction

  function automatic bit exp_master_pin(int n, int d);
    return ((n - 1) / (d + 1)) % 2 == 1;
  endfunction

  // master=1 runs the driven-clock mode, else asynchronous with ds picking 8 or 16
  task automatic run_mode(input bit master, input bit ds, input int d, input int len, input bit jitter);
    int ovs;
    ovs = ds ? 8 : 16;
    @(negedge clk);
    sync_mode = master; clk_dir_out = master; double_speed = ds;
    divisor = ~12'(d);
    @(negedge clk);
    divisor = 12'(d);
    for (int n = 0; n <= len; n++) begin
      if (n > 0) begin
        @(negedge clk);
        if (jitter) begin
          if (master) double_speed = 1'($urandom);
          else xck_in = 1'($urandom);
        end
      end
      #1;
      if (master) begin
        chk(tx_tick, exp_master_tx(n, d), "R5 master tx_tick", n);
        chk(rx_tick, exp_master_rx(n, d), "R5 master rx_tick", n);
        chk(xck_oe, 1'b1, "R5 master xck_oe", n);
        if (n > 0) chk(xck_out, exp_master_pin(n, d), jitter ? "R6 R1 master pin" : "R1 master pin", n);
      end else begin
        chk(tx_tick, exp_async_tx(n, d, ovs), ds ? "R3 R9 fast tx_tick" : "R2 R9 normal tx_tick", n);
        chk(rx_tick, exp_async_rx(n, d, ovs), "R4 mid-bit rx_tick", n);
        chk(xck_oe | xck_out, 1'b0, "R8 async pin idle", n);
      end
    end
  endtask

  task automatic run_slave(input int half, input int edges);
    @(negedge clk);
    xck_in = 1'b0; sync_mode = 1'b1; clk_dir_out = 1'b0;
    double_speed = 1'($urandom);
    repeat (4) @(negedge clk);
    for (int e = 0; e < edges; e++) begin
      xck_in = ~xck_in;
      for (int n = 0; n < half; n++) begin
        if (n > 0) @(negedge clk);
        #1;
        chk(rx_tick, (n == 2) && xck_in, "R7 slave rx_tick", n);
        chk(tx_tick, (n == 2) && !xck_in, "R7 slave tx_tick", n);
        chk(xck_oe | xck_out, 1'b0, "R7 slave pin idle", n);
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(tx_tick, 1'b0, "R10 reset tx_tick", 0);
    chk(rx_tick, 1'b0, "R10 reset rx_tick", 0);
    chk(xck_out, 1'b0, "R10 reset xck_out", 0);
    @(negedge clk);
    rst_n = 1'b1;

    run_mode(1'b0, 1'b0, 0, 60, 1'b0);
    run_mode(1'b0, 1'b0, 3, 200, 1'b0);
    run_mode(1'b0, 1'b0, 1, 20, 1'b0);
    run_mode(1'b0, 1'b1, 0, 40, 1'b1);
    run_mode(1'b0, 1'b1, 5, 150, 1'b1);
    run_mode(1'b1, 1'b0, 0, 40, 1'b0);
    run_mode(1'b1, 1'b1, 2, 60, 1'b1);
    run_mode(1'b1, 1'b0, 4095, 8200, 1'b0);
    run_slave(3, 10);
    run_slave(5, 8);
    run_mode(1'b0, 1'b0, 2, 100, 1'b1);
    for (int i = 0; i < 10; i++) begin
      int d, kind;
      d = int'($urandom % 6);
      kind = int'($urandom % 4);
      case (kind)
        0: run_mode(1'b0, 1'b0, d, 48 * (d + 1) + 3, 1'($urandom));
        1: run_mode(1'b0, 1'b1, d, 24 * (d + 1) + 3, 1'($urandom));
        2: run_mode(1'b1, 1'b0, d, 8 * (d + 1) + 3, 1'($urandom));
        default: run_slave(3 + int'($urandom % 4), 6);
      endcase
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule